// File: doc/BRIEF.md
# Parallel flash configuration autoloader

After reset this block reads a short record from the top of a byte-wide parallel flash and loads eight configuration bytes into a register file. While the system reset is low and for a short time afterwards, the block owns a set of shared pins. It drives the flash address, the active-low chip-select and the active-low read-strobe on them, and it keeps the write-strobe inactive. Each read walks one byte down from the highest address.

Three bytes of the record are signatures, and the block checks each one as soon as it has read it. A bad signature ends the sequence at once, and nothing is loaded. When every signature matches, the block reads eight more configuration bytes into a holding register and copies them to the output register file in one step at the end. The busy output is high the whole time. The host bus logic uses it to answer accesses with a retry. A one-cycle done pulse ends the sequence, and the shared pins then return to normal use. Data from a serial EEPROM can be presented on a side input at any time, and it always replaces the flash data.

Top module: `flash_cfg_loader`

## Requirements
- R1: The first read begins a fixed START_DLY clock cycles after the system reset is released. Chip-select and read-strobe are first seen low after the START_DLY-th rising edge that follows the release.
- R2: During each read, chip-select and read-strobe are both low for exactly CYC_LEN consecutive cycles. Between two reads they return high for exactly one cycle. The write-strobe stays high at all times.
- R3: Read n (counting from 0) uses address TOP-n, where TOP is the all-ones address, and that address holds steady while the strobe is low.
- R4: Read 0 must return 0xAA and read 1 must return 0x55. If either byte is wrong, no further read is made (1 or 2 reads in total).
- R5: Read 3 (address TOP-3) must return 0x55. If it does not, the sequence stops after 4 reads. The byte from read 2 is not checked.
- R6: When all signatures match, exactly 12 reads are made. Configuration byte k (bits 8k+7..8k of cfg_data_o) is the byte returned by read 4+k.
- R7: busy_o and pins_own_o stay high from reset through the cycle in which done_o is high. They are low in every cycle after that.
- R8: done_o is high for exactly one cycle per reset. On a load from flash, cfg_valid_o rises in the cycle after done_o and then stays high.
- R9: The flash data bus is sampled only on the last cycle of each strobe-low period. Its value in earlier cycles of the read has no effect.
- R10: A pulse on eeprom_vld_i loads eeprom_cfg_i into cfg_data_o and sets cfg_valid_o. After that, a later flash commit does not change cfg_data_o, and this holds whether the EEPROM data arrives before or after the flash load.
- R11: If a signature fails and no EEPROM data arrives, cfg_valid_o stays low and cfg_data_o stays zero.
- R12: While rst_ni is low: busy_o and pins_own_o are high; chip-select and read-strobe are high; done_o and cfg_valid_o are low; cfg_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset; releasing it starts the load |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_data_i | input | 8 | Flash read data |
| flash_cs_no | output | 1 | Flash chip-select, active low |
| flash_rd_no | output | 1 | Flash read-strobe, active low |
| flash_wr_no | output | 1 | Flash write-strobe, held high |
| pins_own_o | output | 1 | High while the loader owns the shared pins |
| busy_o | output | 1 | Load in progress; host accesses get a retry |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| eeprom_vld_i | input | 1 | Pulse: EEPROM configuration data is valid |
| eeprom_cfg_i | input | 8*N_CFG | EEPROM configuration bytes |
| cfg_valid_o | output | 1 | Configuration register file holds loaded data |
| cfg_data_o | output | 8*N_CFG | Configuration register file contents |

## Verification
The bench counts rising edges from reset release. It expects the first strobe after exactly START_DLY edges. Each read lasts CYC_LEN strobe-low cycles, followed by a one-cycle gap. The configuration register file changes one cycle after the done pulse. Outputs are sampled at the falling edge after each rising edge. The bench presents valid flash data only in the final strobe-low cycle before the sampling edge and inverted data in the earlier cycles, so sampling at any other point gives a wrong result. Read count, address sequence, busy window and final register contents are compared with values the bench computes from the memory image and the EEPROM timing of each case.

// File: rtl/flash_ldr_pkg.sv
package flash_ldr_pkg;
  localparam logic [7:0] SIG_HI = 8'hAA;
  localparam logic [7:0] SIG_LO = 8'h55;
  localparam int unsigned SIG0_IDX = 0;
  localparam int unsigned SIG1_IDX = 1;
  localparam int unsigned SIG2_IDX = 3;
  localparam int unsigned STAGE_BASE = 4;

  typedef enum logic [2:0] {
    S_WAIT,
    S_READ,
    S_GAP,
    S_FIN,
    S_REL
  } ldr_state_e;
endpackage

// File: rtl/flash_ldr_timer.sv
module flash_ldr_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = en_i && (cnt_q == limit_i);

  // R2: counter never runs past the window it measures
  p_cnt_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= limit_i);
endmodule

// File: rtl/flash_ldr_seq.sv
module flash_ldr_seq
  import flash_ldr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned N_READS   = 12,
  parameter int unsigned START_DLY = 33,
  parameter int unsigned CYC_LEN   = 360,
  parameter int unsigned TMR_W     = 9,
  parameter int unsigned IDX_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        data_i,
  input  logic              tmr_last_i,
  output logic              tmr_en_o,
  output logic              tmr_clr_o,
  output logic [TMR_W-1:0]  tmr_limit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_no,
  output logic              rd_no,
  output logic              busy_o,
  output logic              own_o,
  output logic              done_o,
  output logic              sample_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              commit_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N_READS - 1);

  ldr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pass_q, pass_d;
  logic             sig_bad;

  always_comb begin
    sig_bad = 1'b0;
    if (idx_q == IDX_W'(SIG0_IDX) && data_i != SIG_HI) sig_bad = 1'b1;
    if (idx_q == IDX_W'(SIG1_IDX) && data_i != SIG_LO) sig_bad = 1'b1;
    if (idx_q == IDX_W'(SIG2_IDX) && data_i != SIG_LO) sig_bad = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    unique case (state_q)
      S_WAIT: if (tmr_last_i) state_d = S_READ;
      S_READ: if (tmr_last_i) begin
        if (sig_bad) begin
          state_d = S_FIN;
          pass_d  = 1'b0;
        end else if (idx_q == LAST_IDX) begin
          state_d = S_FIN;
          pass_d  = 1'b1;
        end else begin
          state_d = S_GAP;
          idx_d   = idx_q + 1'b1;  // address settles during the gap
        end
      end
      S_GAP:  state_d = S_READ;
      S_FIN:  state_d = S_REL;
      S_REL:  state_d = S_REL;
      default: state_d = S_REL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_WAIT;
      idx_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
    end
  end

  assign tmr_en_o    = (state_q == S_WAIT) || (state_q == S_READ);
  assign tmr_clr_o   = tmr_last_i || (state_q == S_GAP);
  assign tmr_limit_o = (state_q == S_WAIT) ? TMR_W'(START_DLY - 1) : TMR_W'(CYC_LEN - 1);
  assign addr_o      = (state_q == S_REL) ? '0 : TOP_ADDR - ADDR_W'(idx_q);
  assign cs_no       = (state_q != S_READ);
  assign rd_no       = (state_q != S_READ);
  assign busy_o      = (state_q != S_REL);
  assign own_o       = (state_q != S_REL);
  assign done_o      = (state_q == S_FIN);
  assign sample_o    = (state_q == S_READ) && tmr_last_i;
  assign idx_o       = idx_q;
  assign commit_o    = (state_q == S_FIN) && pass_q;

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && $past(!rd_no)) |-> $stable(addr_o));
  p_done_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !own_o && !done_o));
  p_release_final_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_o |=> (!own_o && rd_no && cs_no));
  p_read_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  p_commit_after_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (idx_q == LAST_IDX));
endmodule

// File: rtl/flash_ldr_cfg_rf.sv
module flash_ldr_cfg_rf
  import flash_ldr_pkg::*;
#(
  parameter int unsigned N_CFG = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         data_i,
  input  logic               commit_i,
  input  logic               eeprom_vld_i,
  input  logic [8*N_CFG-1:0] eeprom_cfg_i,
  output logic               cfg_valid_o,
  output logic [8*N_CFG-1:0] cfg_data_o
);
  logic [8*N_CFG-1:0] stage_flat;
  logic [8*N_CFG-1:0] cfg_q;
  logic               valid_q;
  logic               eep_lock_q;

  for (genvar k = 0; k < N_CFG; k++) begin : g_stage
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (sample_i && idx_i == IDX_W'(STAGE_BASE + k)) byte_q <= data_i;
    end
    assign stage_flat[8*k +: 8] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      valid_q    <= 1'b0;
      eep_lock_q <= 1'b0;
    end else if (eeprom_vld_i) begin
      cfg_q      <= eeprom_cfg_i;
      valid_q    <= 1'b1;
      eep_lock_q <= 1'b1;
    end else if (commit_i && !eep_lock_q) begin
      cfg_q   <= stage_flat;
      valid_q <= 1'b1;
    end
  end

  assign cfg_valid_o = valid_q;
  assign cfg_data_o  = cfg_q;

  p_valid_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> cfg_valid_o);
  p_eeprom_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eep_lock_q && !eeprom_vld_i) |=> $stable(cfg_data_o));
  p_no_load_no_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !eeprom_vld_i) |=> $stable(cfg_data_o));
endmodule

// File: rtl/flash_cfg_loader.sv
module flash_cfg_loader
  import flash_ldr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned N_CFG     = 8,
  parameter int unsigned START_DLY = 33,
  parameter int unsigned CYC_LEN   = 360
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  flash_addr_o,
  input  logic [7:0]         flash_data_i,
  output logic               flash_cs_no,
  output logic               flash_rd_no,
  output logic               flash_wr_no,
  output logic               pins_own_o,
  output logic               busy_o,
  output logic               done_o,
  input  logic               eeprom_vld_i,
  input  logic [8*N_CFG-1:0] eeprom_cfg_i,
  output logic               cfg_valid_o,
  output logic [8*N_CFG-1:0] cfg_data_o
);
  localparam int unsigned N_READS = STAGE_BASE + N_CFG;
  localparam int unsigned IDX_W   = $clog2(N_READS);
  localparam int unsigned TMR_MAX = (START_DLY > CYC_LEN) ? START_DLY : CYC_LEN;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  logic             tmr_en, tmr_clr, tmr_last;
  logic [TMR_W-1:0] tmr_limit;
  logic             sample;
  logic [IDX_W-1:0] idx;
  logic             commit;

  flash_ldr_timer #(.W(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tmr_en),
    .clr_i   (tmr_clr),
    .limit_i (tmr_limit),
    .last_o  (tmr_last)
  );

  flash_ldr_seq #(
    .ADDR_W    (ADDR_W),
    .N_READS   (N_READS),
    .START_DLY (START_DLY),
    .CYC_LEN   (CYC_LEN),
    .TMR_W     (TMR_W),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (flash_data_i),
    .tmr_last_i  (tmr_last),
    .tmr_en_o    (tmr_en),
    .tmr_clr_o   (tmr_clr),
    .tmr_limit_o (tmr_limit),
    .addr_o      (flash_addr_o),
    .cs_no       (flash_cs_no),
    .rd_no       (flash_rd_no),
    .busy_o      (busy_o),
    .own_o       (pins_own_o),
    .done_o      (done_o),
    .sample_o    (sample),
    .idx_o       (idx),
    .commit_o    (commit)
  );

  flash_ldr_cfg_rf #(.N_CFG(N_CFG), .IDX_W(IDX_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_i     (sample),
    .idx_i        (idx),
    .data_i       (flash_data_i),
    .commit_i     (commit),
    .eeprom_vld_i (eeprom_vld_i),
    .eeprom_cfg_i (eeprom_cfg_i),
    .cfg_valid_o  (cfg_valid_o),
    .cfg_data_o   (cfg_data_o)
  );

  assign flash_wr_no = 1'b1;

  p_strobe_only_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_cs_no |-> (busy_o && pins_own_o && !done_o));
endmodule

// File: tb/flash_cfg_loader_tb.sv
module flash_cfg_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int N_CFG      = 8;
  localparam int START_DLY  = 5;
  localparam int CYC_LEN    = 4;
  localparam int N_READS    = 4 + N_CFG;
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [ADDR_W-1:0]  flash_addr_o;
  logic [7:0]         flash_data_i = 8'h00;
  logic               flash_cs_no, flash_rd_no, flash_wr_no;
  logic               pins_own_o, busy_o, done_o;
  logic               eeprom_vld_i = 1'b0;
  logic [8*N_CFG-1:0] eeprom_cfg_i = '0;
  logic               cfg_valid_o;
  logic [8*N_CFG-1:0] cfg_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] img [N_READS];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_cfg_loader #(
    .ADDR_W(ADDR_W), .N_CFG(N_CFG), .START_DLY(START_DLY), .CYC_LEN(CYC_LEN)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flash_addr_o(flash_addr_o),
    .flash_data_i(flash_data_i), .flash_cs_no(flash_cs_no),
    .flash_rd_no(flash_rd_no), .flash_wr_no(flash_wr_no),
    .pins_own_o(pins_own_o), .busy_o(busy_o), .done_o(done_o),
    .eeprom_vld_i(eeprom_vld_i), .eeprom_cfg_i(eeprom_cfg_i),
    .cfg_valid_o(cfg_valid_o), .cfg_data_o(cfg_data_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_reads();
    if (img[0] != 8'hAA) return 1;
    if (img[1] != 8'h55) return 2;
    if (img[3] != 8'h55) return 4;
    return N_READS;
  endfunction

  function automatic logic [8*N_CFG-1:0] exp_flash_cfg();
    logic [8*N_CFG-1:0] v;
    for (int k = 0; k < N_CFG; k++) v[8*k +: 8] = img[4+k];
    return v;
  endfunction

  // eep_mode: 0 none, 1 pulse early in the load, 2 pulse after done
  task automatic run_case(input string tag, input int eep_mode,
                          input logic [8*N_CFG-1:0] eep_val);
    int cyc = 0, reads = 0, low_run = 0, high_run = 0, first_low = -1;
    int done_cyc = -1, done_cnt = 0;
    int bad_len = 0, bad_gap = 0, bad_addr = 0, bad_wr = 0, bad_busy = 0;
    bit valid_at_done = 1'b0, valid_after = 1'b0;
    int n_exp = exp_reads();
    bit commit = (n_exp == N_READS);
    logic [8*N_CFG-1:0] exp_cfg;

    eeprom_cfg_i = eep_val;
    eeprom_vld_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(busy_o && pins_own_o && flash_cs_no && flash_rd_no && !done_o &&
          !cfg_valid_o && cfg_data_o == '0, "R12", {tag, " reset state"},
          {busy_o, pins_own_o, flash_cs_no, flash_rd_no, done_o, cfg_valid_o}, 6'b111100);
    rst_ni = 1'b1;

    while (done_cyc < 0 || cyc < done_cyc + 5) begin
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
      if (cyc > 2000) begin
        check(1'b0, "R6", {tag, " watchdog, no done"}, cyc, 0);
        break;
      end
      if (!flash_wr_no) bad_wr++;
      if (!flash_cs_no || !flash_rd_no) begin
        if (flash_cs_no != flash_rd_no) bad_len++;
        if (low_run == 0) begin
          if (reads == 0) first_low = cyc;
          else if (high_run != 1) bad_gap++;
          if (flash_addr_o != TOP - ADDR_W'(reads)) bad_addr++;
          reads++;
        end else if (flash_addr_o != TOP - ADDR_W'(reads - 1)) bad_addr++;
        low_run++;
        high_run = 0;
      end else begin
        if (low_run != 0 && low_run != CYC_LEN) bad_len++;
        low_run = 0;
        high_run++;
      end
      // R9: valid data only ahead of the sampling edge
      if (low_run > 0 && reads <= N_READS)
        flash_data_i = (low_run == CYC_LEN) ? img[reads-1] : ~img[reads-1];
      else
        flash_data_i = 8'h00;

      if (done_cyc >= 0 && cyc == done_cyc + 1) valid_after = cfg_valid_o;
      if (done_o) begin
        done_cnt++;
        if (done_cyc < 0) begin
          done_cyc = cyc;
          valid_at_done = cfg_valid_o;
        end
      end
      if (done_cyc < 0 || cyc == done_cyc) begin
        if (!busy_o || !pins_own_o) bad_busy++;
      end else if (busy_o || pins_own_o) bad_busy++;

      eeprom_vld_i = (eep_mode == 1 && cyc == 2) ||
                     (eep_mode == 2 && done_cyc >= 0 && cyc == done_cyc + 2);
    end
    eeprom_vld_i = 1'b0;
    @(negedge clk_i);

    check(first_low == START_DLY, "R1", {tag, " start delay"}, first_low, START_DLY);
    check(bad_len == 0, "R2", {tag, " strobe-low length"}, bad_len, 0);
    check(bad_gap == 0, "R2", {tag, " gap between reads"}, bad_gap, 0);
    check(bad_wr == 0, "R2", {tag, " write-strobe high"}, bad_wr, 0);
    check(bad_addr == 0, "R3", {tag, " address sequence"}, bad_addr, 0);
    if (n_exp < 4)
      check(reads == n_exp, "R4", {tag, " read count"}, reads, n_exp);
    else if (n_exp == 4)
      check(reads == n_exp, "R5", {tag, " read count"}, reads, n_exp);
    else
      check(reads == n_exp, "R6", {tag, " read count"}, reads, n_exp);
    check(bad_busy == 0, "R7", {tag, " busy/own window"}, bad_busy, 0);
    check(done_cnt == 1, "R8", {tag, " done pulse count"}, done_cnt, 1);
    if (eep_mode != 1 && commit)
      check(!valid_at_done && valid_after, "R8", {tag, " valid timing"},
            {valid_at_done, valid_after}, 2'b01);

    if (eep_mode != 0) exp_cfg = eep_val;
    else if (commit)   exp_cfg = exp_flash_cfg();
    else               exp_cfg = '0;
    if (eep_mode != 0)
      check(cfg_data_o == exp_cfg && cfg_valid_o, "R10", {tag, " eeprom priority"},
            cfg_data_o, exp_cfg);
    else if (commit)
      check(cfg_data_o == exp_cfg && cfg_valid_o, "R6", {tag, " config bytes (R9 sampling)"},
            cfg_data_o, exp_cfg);
    else
      check(cfg_data_o == '0 && !cfg_valid_o, "R11", {tag, " no load on bad signature"},
            {cfg_valid_o, cfg_data_o}, 0);
  endtask

  task automatic good_image();
    img[0] = 8'hAA; img[1] = 8'h55; img[2] = 8'h3C; img[3] = 8'h55;
    for (int k = 4; k < N_READS; k++) img[k] = 8'(8'h10 + 8'(k) * 8'h11);
  endtask

  initial begin
    void'($urandom(32'd4711));
    good_image();
    run_case("good", 0, '0);
    good_image(); img[0] = 8'hAB;
    run_case("bad_sig0", 0, '0);
    good_image(); img[1] = 8'h54;
    run_case("bad_sig1", 0, '0);
    good_image(); img[3] = 8'hAA;
    run_case("bad_sig2", 0, '0);
    good_image(); img[2] = 8'h00;
    run_case("byte2_unchecked", 0, '0);
    good_image();
    run_case("eep_early", 1, 64'hDEAD_BEEF_0123_4567);
    good_image();
    run_case("eep_late", 2, 64'hCAFE_F00D_8899_AABB);
    good_image(); img[0] = 8'h00;
    run_case("eep_bad_flash", 1, 64'h1122_3344_5566_7788);
    for (int i = 0; i < 20; i++) begin
      for (int k = 0; k < N_READS; k++) img[k] = 8'($urandom);
      img[0] = ($urandom % 5 != 0) ? 8'hAA : 8'($urandom);
      img[1] = ($urandom % 5 != 0) ? 8'h55 : 8'($urandom);
      img[3] = ($urandom % 5 != 0) ? 8'h55 : 8'($urandom);
      run_case($sformatf("rand%0d", i), int'($urandom % 3),
               {$urandom, $urandom});
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL R6 global watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule